// File: doc/BRIEF.md
# Timer Capture Unit with Event Prescaler

This block records the value of a free-running timer at the moment a qualifying event is seen on an external input pin. The pin is brought into the clock domain through a synchronizer. An edge detector then looks for edges, and a small counter can thin out rising edges so that only every fourth or every sixteenth one causes a capture. Each capture copies the full timer value into a capture register and raises a sticky interrupt flag. The flag stays high until software strobes the clear input.

A four-bit mode input selects what counts as an event. The counter is only cleared when the block leaves capture operation. If the mode is moved straight from one prescale ratio to another, the partial count is carried over. A change of the mode field is also treated as a possible edge, because the edge selector changes under a pin that may already sit at the new active level. As a result, a mode change can raise the flag even though the pin did not move.

Top module: `tcap_unit`

## Requirements
- R1: After reset the capture output is all zeros, the flag is low and the prescale count is zero.
- R2: A pin change first sampled at clock edge k causes a capture at edge k+2. The capture register takes the timer value present at that edge, and the flag is high from that edge on.
- R3: Mode 4'b0100 captures on every falling edge of the pin and ignores rising edges.
- R4: Mode 4'b0101 captures on every rising edge of the pin and ignores falling edges.
- R5: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge, counted from a count of zero.
- R6: The flag stays high while flag_clr_i is low. A one-cycle high on flag_clr_i with no capture in the same cycle drives it low at the next edge.
- R7: When a capture and flag_clr_i fall on the same edge, the flag ends up high.
- R8: A new capture overwrites the capture register even while the flag from an earlier capture is still high.
- R9: Mode 4'b0000, and every value whose upper two bits are not 01, performs no capture and clears the prescale count. A later move into a prescaled mode restarts counting from zero.
- R10: Moving directly between the 4'b0110 and 4'b0111 modes keeps the prescale count. For example, three rising edges counted under 4'b0111 followed by a switch to 4'b0110 give a capture on the very next rising edge.
- R11: At the first edge after the mode field takes a new capture value, one event is counted if the synchronized pin level already equals that mode's active level: high for rising modes, low for the falling mode. No event is counted otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External event pin (asynchronous) |
| timer_i | input | 16 | Free-running timer value |
| mode_i | input | 4 | Capture mode field |
| flag_clr_i | input | 1 | Software flag clear strobe |
| cap_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture flag |

## Verification
A pin change driven between edges appears in cap_o and flag_o three edges later: two synchronizer stages plus the capture register. A mode change that produces a spurious event shows up after a single edge, and a flag clear also takes effect after one edge. Each driver step queues its expected capture value and flag with the exact cycle in which they are due. The monitor compares them in the half cycle after that edge, and cycle counts before that point are checked to show that no capture has happened yet.

// File: rtl/capu_pkg.sv
package capu_pkg;
    localparam int unsigned MODE_W     = 4;
    localparam int unsigned RATIO_MID  = 4;
    localparam int unsigned RATIO_HIGH = 16;
    localparam int unsigned PS_W       = $clog2(RATIO_HIGH);

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 4'b0000,
        MODE_FALL   = 4'b0100,
        MODE_RISE1  = 4'b0101,
        MODE_RISE4  = 4'b0110,
        MODE_RISE16 = 4'b0111
    } cap_mode_e;

    function automatic logic mode_is_capture(logic [MODE_W-1:0] m);
        return (m == MODE_FALL) || (m == MODE_RISE1) ||
               (m == MODE_RISE4) || (m == MODE_RISE16);
    endfunction

    function automatic logic mode_is_fall(logic [MODE_W-1:0] m);
        return m == MODE_FALL;
    endfunction

    function automatic logic [PS_W-1:0] mode_last(logic [MODE_W-1:0] m);
        logic [PS_W-1:0] r;
        case (m)
            MODE_RISE4:  r = PS_W'(RATIO_MID - 1);
            MODE_RISE16: r = PS_W'(RATIO_HIGH - 1);
            default:     r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/capu_sync.sv
module capu_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = (st_q.sh << 1) | STAGES'(pin_i);
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sh[STAGES-1];
    assign rise_o  = level_o & ~st_q.prev;
    assign fall_o  = ~level_o & st_q.prev;

    // R2
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/capu_prescale.sv
module capu_prescale #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             fire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ps_t;

    ps_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = en_i && evt_i && (st_q.cnt >= last_i);
        if (!en_i)       st_d.cnt = '0;
        else if (fire_o) st_d.cnt = '0;
        else if (evt_i)  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    cnt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == '0));
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && evt_i && !fire_o) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import capu_pkg::*;
#(
    parameter int unsigned TMR_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic [TMR_W-1:0]  timer_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              flag_clr_i,
    output logic [TMR_W-1:0]  cap_o,
    output logic              flag_o
);
    typedef struct packed {
        logic [TMR_W-1:0]  cap;
        logic              flag;
        logic [MODE_W-1:0] mode;
    } top_t;

    top_t st_d, st_q;

    logic lvl, rise, fall, fire;
    logic cap_en, fall_sel, mode_chg, glitch, evt;

    capu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        cap_en   = mode_is_capture(mode_i);
        fall_sel = mode_is_fall(mode_i);
        mode_chg = (mode_i != st_q.mode);
        glitch   = cap_en && mode_chg && (fall_sel ? ~lvl : lvl);
        evt      = (cap_en && (fall_sel ? fall : rise)) || glitch;
    end

    capu_prescale #(.CNT_W(PS_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cap_en),
        .evt_i  (evt),
        .last_i (mode_last(mode_i)),
        .fire_o (fire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        if (fire) st_d.cap = timer_i;
        st_d.flag = fire || (st_q.flag && !flag_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_o == $past(timer_i)));
    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_o));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_o);
    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !fire) |=> !flag_o);
    // R9
    no_cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_is_capture(mode_i) |-> !fire);
endmodule

// File: tb/sim_tcap_unit.sv
module sim_tcap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] timer = 16'h0;
    logic [3:0]  mode = 4'b0000;
    logic        clr = 1'b0;
    logic [15:0] cap;
    logic        flag;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] cap;
        logic        flag;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tcap_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin),
        .timer_i    (timer),
        .mode_i     (mode),
        .flag_clr_i (clr),
        .cap_o      (cap),
        .flag_o     (flag)
    );

    // monitor: compares due items half a cycle after their edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.due != cyc || cap !== e.cap || flag !== e.flag) begin
                errors++;
                $display("FAIL %s: cap=%h flag=%b expected cap=%h flag=%b (cycle %0d due %0d)",
                         e.req, cap, flag, e.cap, e.flag, cyc, e.due);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_in(int d, logic [15:0] c, logic f, string r);
        exp_t e;
        e.due = cyc + d; e.cap = c; e.flag = f; e.req = r;
        sb.push_back(e);
    endtask

    task automatic pulse();
        pin = 1'b1; step(4);
        pin = 1'b0; step(4);
    endtask

    task automatic clear_flag(logic [15:0] c);
        clr = 1'b1;
        expect_in(1, c, 1'b0, "R6");
        step(1);
        clr = 1'b0;
        step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_in(1, 16'h0000, 1'b0, "R1");
        step(2);

        // falling mode entered with pin low: spurious event one edge later
        timer = 16'h1111; mode = 4'b0100;
        expect_in(1, 16'h1111, 1'b1, "R11");
        step(2);
        clear_flag(16'h1111);

        // R3: rising edge ignored, falling edge captured
        timer = 16'h2222; pin = 1'b1;
        expect_in(3, 16'h1111, 1'b0, "R3");
        step(4);
        timer = 16'h3333; pin = 1'b0;
        expect_in(3, 16'h3333, 1'b1, "R3");
        step(4);
        step(5);
        expect_in(1, 16'h3333, 1'b1, "R6");
        step(2);
        clear_flag(16'h3333);

        // R2: exact latency of three edges
        pin = 1'b1; step(4);
        timer = 16'h4444; pin = 1'b0;
        expect_in(2, 16'h3333, 1'b0, "R2");
        expect_in(3, 16'h4444, 1'b1, "R2");
        step(4);
        clear_flag(16'h4444);

        // R7: clear and capture on the same edge
        pin = 1'b1; step(4);
        timer = 16'h5555; pin = 1'b0;
        step(2);
        clr = 1'b1;
        expect_in(1, 16'h5555, 1'b1, "R7");
        step(1);
        clr = 1'b0;
        step(2);

        // R8: overwrite while flag still high
        pin = 1'b1; step(4);
        timer = 16'h6666; pin = 1'b0;
        expect_in(3, 16'h6666, 1'b1, "R8");
        step(4);
        clear_flag(16'h6666);

        // R11: change to rising mode with pin low gives no event
        mode = 4'b0101;
        expect_in(1, 16'h6666, 1'b0, "R11");
        step(2);
        timer = 16'h7777; pin = 1'b1;
        expect_in(3, 16'h7777, 1'b1, "R4");
        step(4);
        clear_flag(16'h7777);
        timer = 16'h8888; pin = 1'b0;
        expect_in(3, 16'h7777, 1'b0, "R4");
        step(4);

        // R5: every 4th rising edge
        mode = 4'b0110; step(2);
        for (int i = 0; i < 3; i++) pulse();
        expect_in(1, 16'h7777, 1'b0, "R5");
        step(2);
        timer = 16'h9999; pin = 1'b1;
        expect_in(3, 16'h9999, 1'b1, "R5");
        step(4);
        pin = 1'b0; step(4);
        clear_flag(16'h9999);

        // R5: every 16th rising edge
        mode = 4'b0111; step(2);
        for (int i = 0; i < 15; i++) pulse();
        expect_in(1, 16'h9999, 1'b0, "R5");
        step(2);
        timer = 16'hAAAA; pin = 1'b1;
        expect_in(3, 16'hAAAA, 1'b1, "R5");
        step(4);
        pin = 1'b0; step(4);
        clear_flag(16'hAAAA);

        // R10: partial count carried from /16 into /4
        for (int i = 0; i < 3; i++) pulse();
        mode = 4'b0110; step(2);
        timer = 16'hBBBB; pin = 1'b1;
        expect_in(3, 16'hBBBB, 1'b1, "R10");
        step(4);
        pin = 1'b0; step(4);
        clear_flag(16'hBBBB);

        // R9: off mode clears a partial count
        for (int i = 0; i < 2; i++) pulse();
        mode = 4'b0000; step(2);
        mode = 4'b0110; step(2);
        for (int i = 0; i < 2; i++) pulse();
        expect_in(1, 16'hBBBB, 1'b0, "R9");
        step(2);
        pulse();
        timer = 16'hCCCC; pin = 1'b1;
        expect_in(3, 16'hCCCC, 1'b1, "R9");
        step(4);
        pin = 1'b0; step(4);
        clear_flag(16'hCCCC);

        // R9: other non-capture value ignores edges
        mode = 4'b1011; step(2);
        pin = 1'b1;
        expect_in(3, 16'hCCCC, 1'b0, "R9");
        step(4);

        // R11: move into rising mode with pin already high
        timer = 16'hDDDD; mode = 4'b0101;
        expect_in(1, 16'hDDDD, 1'b1, "R11");
        step(2);
        pin = 1'b0; step(4);
        clear_flag(16'hDDDD);

        step(4);
        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: %0d items never checked, expected 0", sb.size());
        end
        finish_run();
    end
endmodule